// File: doc/BRIEF.md
# Processor Clock Throttle Control Block

This block sits on a simple register bus next to one processor and turns two small registers into clock control. A 32-bit control word carries a throttle-enable bit and a duty value. While throttling is on, a duty-cycle generator drives a clock-enable output: the gating cell downstream lets the clock through only on cycles where that enable is high. The duty value occupies a span of the control word whose low bit position and width are elaboration parameters. Control bits outside that span and outside the enable bit are stored and read back, but they have no effect on the clock.

A second, byte-wide register at offset 4 holds no state. Reading it returns zero and emits a one-cycle request to the processor's power sequencer to enter the C2 low-power state. Writes to it are dropped.

Software is expected to clear the enable before it changes the duty value. If the duty value changes while the enable stays set, the new value is stored but not applied, and a sticky error output records the misuse. A sleep-reset input clears all state, as the power-on reset does, because the register contents do not survive deep sleep or soft-off.

Top module: `thr_blk`

## Requirements
- R1: After reset (`rst`) the control word reads 0, `bus_rdata` is 0, `clk_en` is 1, and both `c2_req` and `duty_err` are 0.
- R2: A write at byte offset 0 stores all 32 bits of `bus_wdata`. A read at offset 0 returns the stored word on `bus_rdata` in the cycle after the read is accepted.
- R3: A read at offset 4 returns 0 on `bus_rdata`. A write at offset 4 leaves the control word unchanged.
- R4: Every accepted read at offset 4 drives `c2_req` high for exactly the following cycle. N back-to-back reads give N consecutive high cycles. A read at offset 0 does not raise `c2_req`.
- R5: Control bit 4 is the throttle enable. While it is 0, `clk_en` is 1 from the cycle after it was cleared onward.
- R6: The duty value is control bits [DUTY_OFF+DUTY_W-1:DUTY_OFF] (the defaults select bits [3:1]). When the enable rises with duty d, the output after the j-th following clock edge (j=1,2,...) is `clk_en = ((j-1) mod 2^DUTY_W) >= d`. This gives 2^DUTY_W − d high cycles in every 2^DUTY_W. All other control bits apart from bit 4 have no effect on `clk_en`.
- R7: A duty value of 0 with the enable set keeps `clk_en` at 1.
- R8: A control write that keeps bit 4 set while both the old and new bit 4 are 1 and that changes the duty field is stored and sets `duty_err`, which then stays at 1 until reset. The generator keeps the duty value it latched when the enable last rose, until the enable is cleared and set again.
- R9: Pulsing `sleep_rst` returns the block to the reset state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_rst | input | 1 | Synchronous active-high reset on deep-sleep or soft-off exit |
| bus_addr | input | ADDR_W | Byte offset within the block |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; ignored when `bus_wr` is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| clk_en | output | 1 | Registered clock-enable for the external gating cell |
| c2_req | output | 1 | One-cycle request to enter C2 |
| duty_err | output | 1 | Sticky flag: duty value changed while throttling was enabled |

## Verification
The bench builds the block with its defaults: a 3-bit duty field at bits [3:1], which gives an 8-cycle throttle period. At that size every duty value, including 0, can be swept across two full periods and compared bit by bit with the arithmetic pattern. The same sweep leaves junk in the ignored control bits. An 8-cycle window also makes it cheap to count high cycles after an illegal duty change and after re-enabling, which shows which duty value the generator is actually applying.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int unsigned CTRL_W   = 32;
  localparam int unsigned EN_BIT   = 4;
  localparam int unsigned CTRL_OFS = 0;
  localparam int unsigned LVL2_OFS = 4;
endpackage

// File: rtl/thr_regs.sv
module thr_regs
  import thr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned DUTY_OFF = 1,
  parameter int unsigned DUTY_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CTRL_W-1:0] bus_wdata,
  output logic [CTRL_W-1:0] bus_rdata,
  output logic              c2_req,
  output logic              duty_err,
  output logic              thr_en,
  output logic              en_rise,
  output logic [DUTY_W-1:0] new_duty
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_LVL2 = ADDR_W'(LVL2_OFS);

  logic [CTRL_W-1:0] ctrl_q;
  logic              wr_ctrl, rd_acc, rd_lvl2, duty_chg;

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    rd_acc   = bus_rd && !bus_wr;
    rd_lvl2  = rd_acc && (bus_addr == A_LVL2);
    new_duty = bus_wdata[DUTY_OFF +: DUTY_W];
    duty_chg = new_duty != ctrl_q[DUTY_OFF +: DUTY_W];
    en_rise  = wr_ctrl && !ctrl_q[EN_BIT] && bus_wdata[EN_BIT];
    thr_en   = ctrl_q[EN_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      bus_rdata <= '0;
      c2_req    <= 1'b0;
      duty_err  <= 1'b0;
    end else begin
      c2_req <= rd_lvl2;
      if (wr_ctrl) begin
        ctrl_q <= bus_wdata;
        if (ctrl_q[EN_BIT] && bus_wdata[EN_BIT] && duty_chg)
          duty_err <= 1'b1;
      end
      if (rd_acc)
        bus_rdata <= (bus_addr == A_CTRL) ? ctrl_q : '0;
    end
  end

  // R4: a request pulse is only ever caused by a level-2 read one cycle back
  p_c2_cause_r4: assert property (@(posedge clk) disable iff (rst)
    c2_req |-> $past(bus_rd && !bus_wr && bus_addr == A_LVL2));
  // R3: the level-2 read that raised the request returned zero
  p_lvl2_zero_r3: assert property (@(posedge clk) disable iff (rst)
    c2_req |-> (bus_rdata == '0));
  // R8: the error flag never drops outside reset
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    duty_err |=> duty_err);
endmodule

// File: rtl/thr_duty_gen.sv
module thr_duty_gen #(
  parameter int unsigned DUTY_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic [DUTY_W-1:0] load_duty,
  output logic              clk_en
);
  logic [DUTY_W-1:0] duty_act;
  logic [DUTY_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_act <= '0;
      phase    <= '0;
      clk_en   <= 1'b1;
    end else begin
      if (load) begin
        duty_act <= load_duty;
        phase    <= '0;
      end else if (en) begin
        phase <= phase + 1'b1;
      end
      clk_en <= !en || (phase >= duty_act);
    end
  end

  // R5: with throttling off the enable output returns high on the next cycle
  p_off_high_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> clk_en);
  // R7: a zero duty setting never gates the clock
  p_zero_duty_r7: assert property (@(posedge clk) disable iff (rst)
    (duty_act == '0) |=> clk_en);
  // R8: the applied duty is frozen while throttling stays enabled
  p_duty_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en)) |-> $stable(duty_act));
endmodule

// File: rtl/thr_blk.sv
module thr_blk
  import thr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned DUTY_OFF = 1,
  parameter int unsigned DUTY_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              clk_en,
  output logic              c2_req,
  output logic              duty_err
);
  logic              rst_all;
  logic              thr_en, en_rise;
  logic [DUTY_W-1:0] new_duty;

  assign rst_all = rst || sleep_rst;

  thr_regs #(.ADDR_W(ADDR_W), .DUTY_OFF(DUTY_OFF), .DUTY_W(DUTY_W)) u_regs (
    .clk(clk), .rst(rst_all), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .c2_req(c2_req), .duty_err(duty_err), .thr_en(thr_en),
    .en_rise(en_rise), .new_duty(new_duty)
  );

  thr_duty_gen #(.DUTY_W(DUTY_W)) u_gen (
    .clk(clk), .rst(rst_all), .en(thr_en), .load(en_rise),
    .load_duty(new_duty), .clk_en(clk_en)
  );

  // R9: the cycle after any reset source, outputs are at their defaults
  p_reset_dflt_r9: assert property (@(posedge clk)
    $past(rst_all) |-> (clk_en && !c2_req && !duty_err && bus_rdata == '0));
endmodule

// File: tb/thr_blk_tb.sv
module thr_blk_tb;
  localparam int PER = 8;
  logic        clk = 1'b0;
  logic        rst = 1'b1, sleep_rst = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        clk_en, c2_req, duty_err;
  int          errs = 0, checks = 0;
  bit          timeout = 1'b0;

  always #10 clk = ~clk;

  thr_blk u_dut (
    .clk(clk), .rst(rst), .sleep_rst(sleep_rst), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .clk_en(clk_en), .c2_req(c2_req), .duty_err(duty_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic count_high(output int n);
    n = 0;
    for (int k = 0; k < PER; k++) begin
      @(negedge clk);
      if (clk_en) n++;
    end
  endtask

  task automatic run_all();
    int n;
    logic [31:0] junk;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(clk_en == 1'b1, "R1 clk_en", {31'b0, clk_en}, 1);
    chk(c2_req == 1'b0, "R1 c2_req", {31'b0, c2_req}, 0);
    chk(duty_err == 1'b0, "R1 duty_err", {31'b0, duty_err}, 0);
    chk(bus_rdata == 0, "R1 rdata", bus_rdata, 0);
    rd(3'd0);
    chk(bus_rdata == 0, "R1 ctrl reset value", bus_rdata, 0);
    chk(c2_req == 1'b0, "R4 no request on control read", {31'b0, c2_req}, 0);

    // R2 / R3: full-word storage, offset-4 writes dropped
    wr(3'd0, 32'h1234_5668);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd0);
    chk(bus_rdata == 32'h1234_5668, "R2/R3 control readback", bus_rdata, 32'h1234_5668);
    rd(3'd4);
    chk(bus_rdata == 0, "R3 level-2 reads zero", bus_rdata, 0);
    chk(c2_req == 1'b1, "R4 request after level-2 read", {31'b0, c2_req}, 1);
    @(negedge clk);
    chk(c2_req == 1'b0, "R4 single-cycle pulse", {31'b0, c2_req}, 0);

    // R4: three back-to-back level-2 reads
    @(negedge clk); bus_addr = 3'd4; bus_rd = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (k == 2) bus_rd = 1'b0;
      chk(c2_req == 1'b1, "R4 back-to-back pulse", {31'b0, c2_req}, 1);
      chk(bus_rdata == 0, "R3 back-to-back zero", bus_rdata, 0);
    end
    @(negedge clk);
    chk(c2_req == 1'b0, "R4 pulse ends", {31'b0, c2_req}, 0);

    // R5 / R6 / R7: sweep every duty value, junk in ignored bits
    junk = 32'hDEAD_BEE1 & ~32'h0000_001E;
    for (int d = 0; d < PER; d++) begin
      wr(3'd0, junk);
      @(negedge clk);
      chk(clk_en == 1'b1, "R5 high while disabled", {31'b0, clk_en}, 1);
      wr(3'd0, junk | 32'h10 | (32'(d) << 1));
      chk(clk_en == 1'b1, "R5 high before first throttled edge", {31'b0, clk_en}, 1);
      for (int j = 0; j < 2 * PER; j++) begin
        @(negedge clk);
        chk(clk_en == ((j % PER) >= d), d == 0 ? "R7 zero duty pattern" : "R6 duty pattern",
            {31'b0, clk_en}, {31'b0, ((j % PER) >= d)});
      end
    end
    chk(duty_err == 1'b0, "R8 no error from legal sequences", {31'b0, duty_err}, 0);

    // R8: duty change while enabled
    wr(3'd0, 32'h0);
    wr(3'd0, 32'h10 | (32'd2 << 1));
    wr(3'd0, 32'h10 | (32'd5 << 1));
    chk(duty_err == 1'b1, "R8 error raised", {31'b0, duty_err}, 1);
    count_high(n);
    chk(n == PER - 2, "R8 old duty kept", n, PER - 2);
    rd(3'd0);
    chk(bus_rdata == (32'h10 | (32'd5 << 1)), "R8 new value stored", bus_rdata, 32'h1A);
    wr(3'd0, 32'h0);
    wr(3'd0, 32'h10 | (32'd5 << 1));
    count_high(n);
    chk(n == PER - 5, "R8 new duty after re-enable", n, PER - 5);
    chk(duty_err == 1'b1, "R8 error sticky", {31'b0, duty_err}, 1);

    // R9: sleep reset
    @(negedge clk); sleep_rst = 1'b1;
    @(negedge clk); sleep_rst = 1'b0;
    chk(duty_err == 1'b0, "R9 error cleared", {31'b0, duty_err}, 0);
    chk(clk_en == 1'b1, "R9 clk_en high", {31'b0, clk_en}, 1);
    rd(3'd0);
    chk(bus_rdata == 0, "R9 control cleared", bus_rdata, 0);
    count_high(n);
    chk(n == PER, "R9 no throttling after sleep reset", n, PER);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    if (timeout) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=expired expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule